// File: doc/BRIEF.md
# Lockable Software Reset Controller

This block lets software hold a few downstream modules in reset through a simple word-addressed register port. Each channel owns two one-bit registers. One is a control bit whose value drives that channel's active-low reset output directly: 0 holds the module in reset and 1 releases it.

The other is a lock bit. It starts open. Software closes it by writing 0. While it is closed, control writes for that channel are refused. Only a reset of this block reopens a closed lock.

Each accepted control write also raises a one-cycle update strobe. Downstream logic can use it to see that software touched the channel, even when the value did not change. The outputs are plain registers in this block's clock domain. Any synchronisation into other domains happens outside the block.

Top module: `swrst_ctrl`

## Requirements
- R1: In reset and on the first cycle after it, every lock bit reads 1 and every control bit reads 1. Every `rst_no` bit is 1 and every `upd_o` bit is 0.
- R2: A write with bit 0 equal to 0 to a channel's lock word clears that lock. A write with bit 0 equal to 1 to a lock word leaves it unchanged.
- R3: While a channel's lock is 1, a write to its control word loads bit 0 of the write data into the control bit. The channel's `rst_no` bit shows the new value on the cycle after the write.
- R4: While a channel's lock is 0, writes to its control word are ignored. The control bit and `rst_no` stay unchanged, and `upd_o` stays 0.
- R5: Each accepted control write raises that channel's `upd_o` bit for exactly the one cycle after the write. This happens even if the value is unchanged.
- R6: Reads are combinational from `addr_i`. Word i (0 to NUM_CH-1) returns lock i in bit 0. Word NUM_CH+i returns control i in bit 0. All other bits, and all other addresses, read as 0.
- R7: A write to one channel's registers leaves every other channel's lock, control, `rst_no` and `upd_o` unchanged.
- R8: Writes to addresses at or above 2*NUM_CH change no state. Write-data bits above bit 0 have no effect.
- R9: A cleared lock stays 0 until the block is reset. After reset the lock is open again, and control writes are accepted.
- R10: A control write is judged against the lock value held before that clock edge. A control write on the cycle right after a lock-clearing write is refused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe for the register port |
| addr_i | input | AW | Word address |
| wdata_i | input | DW | Write data; only bit 0 is used |
| rdata_o | output | DW | Read data for `addr_i` |
| rst_no | output | NUM_CH | Active-low reset per channel |
| upd_o | output | NUM_CH | One-cycle strobe per accepted control write |

## Verification
The hardest case to reach is a control write landing on a channel that was locked only one cycle earlier. The bench must also show that this refused write leaves both the reset output and the update strobe quiet. The bench drives this sequence directly, back to back. It also runs a pseudo-random stream of writes over mapped and unmapped words, with several block resets in between. This stream locks channels at different times, reopens them through reset, and repeats same-value control writes, which must still strobe. A behavioural model is compared against every output on every cycle.

// File: rtl/swrst_pkg.sv
package swrst_pkg;
  typedef enum logic [1:0] {
    KIND_LOCK = 2'd0,
    KIND_CTRL = 2'd1,
    KIND_NONE = 2'd2
  } reg_kind_e;

  localparam logic LOCK_RESVAL = 1'b1;
  localparam logic CTRL_RESVAL = 1'b1;
endpackage

// File: rtl/swrst_regport.sv
module swrst_regport
  import swrst_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int AW     = 4,
  parameter int DW     = 32
) (
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NUM_CH-1:0] lock_i,
  input  logic [NUM_CH-1:0] ctrl_i,
  output logic [NUM_CH-1:0] lock_we_o,
  output logic [NUM_CH-1:0] ctrl_we_o,
  output logic              wbit_o,
  output logic [DW-1:0]     rdata_o
);
  localparam int NUM_REGS = 2 * NUM_CH;

  reg_kind_e           kind;
  logic [AW-1:0]       ch_idx;
  logic [NUM_CH-1:0]   sel;

  always_comb begin
    if (int'(addr_i) < NUM_CH) begin
      kind   = KIND_LOCK;
      ch_idx = addr_i;
    end else if (int'(addr_i) < NUM_REGS) begin
      kind   = KIND_CTRL;
      ch_idx = addr_i - AW'(NUM_CH);
    end else begin
      kind   = KIND_NONE;
      ch_idx = '0;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign sel[i]       = (ch_idx == AW'(i)) && (kind != KIND_NONE);
    assign lock_we_o[i] = we_i && sel[i] && (kind == KIND_LOCK);
    assign ctrl_we_o[i] = we_i && sel[i] && (kind == KIND_CTRL);
  end

  assign wbit_o = wdata_i[0];

  logic rbit;
  always_comb begin
    rbit = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel[i]) rbit = (kind == KIND_LOCK) ? lock_i[i] : ctrl_i[i];
    end
  end

  assign rdata_o = {{(DW-1){1'b0}}, rbit};

  // R8
  always_comb begin
    assert (!(kind == KIND_NONE) || (lock_we_o == '0 && ctrl_we_o == '0))
      else $error("unmapped_wr_chk");
  end
endmodule

// File: rtl/swrst_chan.sv
module swrst_chan
  import swrst_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_we_i,
  input  logic ctrl_we_i,
  input  logic wbit_i,
  output logic lock_o,
  output logic ctrl_o,
  output logic upd_o
);
  logic lock_q, ctrl_q, upd_q;
  logic accept;

  // control gated by lock state before this edge
  assign accept = ctrl_we_i && lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= LOCK_RESVAL;
      ctrl_q <= CTRL_RESVAL;
      upd_q  <= 1'b0;
    end else begin
      if (lock_we_i && !wbit_i) lock_q <= 1'b0;
      if (accept) ctrl_q <= wbit_i;
      upd_q <= accept;
    end
  end

  assign lock_o = lock_q;
  assign ctrl_o = ctrl_q;
  assign upd_o  = upd_q;

  // R2
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |=> !lock_q);
  // R4
  ctrl_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |=> $stable(ctrl_q));
  // R4
  upd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |=> !upd_q);
  // R5
  upd_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> ctrl_q == $past(wbit_i));
  // R3
  ctrl_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_q) |-> upd_q);
endmodule

// File: rtl/swrst_ctrl.sv
module swrst_ctrl #(
  parameter int NUM_CH = 2,
  parameter int AW     = 4,
  parameter int DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NUM_CH-1:0] rst_no,
  output logic [NUM_CH-1:0] upd_o
);
  logic [NUM_CH-1:0] lock_we, ctrl_we, lock_q, ctrl_q;
  logic              wbit;

  swrst_regport #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW)) u_regport (
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .lock_i   (lock_q),
    .ctrl_i   (ctrl_q),
    .lock_we_o(lock_we),
    .ctrl_we_o(ctrl_we),
    .wbit_o   (wbit),
    .rdata_o  (rdata_o)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    swrst_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .lock_we_i(lock_we[i]),
      .ctrl_we_i(ctrl_we[i]),
      .wbit_i   (wbit),
      .lock_o   (lock_q[i]),
      .ctrl_o   (ctrl_q[i]),
      .upd_o    (upd_o[i])
    );
  end

  assign rst_no = ctrl_q;

  // R6
  rdata_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1:1] == '0);
  // R7
  upd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(upd_o));
endmodule

// File: tb/swrst_ctrl_tb.sv
module swrst_ctrl_tb;
  localparam int NUM_CH = 2;
  localparam int AW     = 4;
  localparam int DW     = 32;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              we = 1'b0;
  logic [AW-1:0]     addr = '0;
  logic [DW-1:0]     wdata = '0;
  logic [DW-1:0]     rdata;
  logic [NUM_CH-1:0] rst_n_o, upd;

  always #4 clk = ~clk;

  swrst_ctrl #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW)) u_dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .we_i   (we),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .rst_no (rst_n_o),
    .upd_o  (upd)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;
  bit  lock_m [NUM_CH];
  bit  ctrl_m [NUM_CH];
  bit  upd_m  [NUM_CH];
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] model_read(int a);
    if (a < NUM_CH) return DW'(lock_m[a]);
    if (a < 2*NUM_CH) return DW'(ctrl_m[a-NUM_CH]);
    return '0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NUM_CH; i++) begin
      lock_m[i] = 1; ctrl_m[i] = 1; upd_m[i] = 0;
    end
  endtask

  // compare every output against the model
  task automatic compare(string tag);
    logic [NUM_CH-1:0] er, eu;
    for (int i = 0; i < NUM_CH; i++) begin
      er[i] = ctrl_m[i];
      eu[i] = upd_m[i];
    end
    check({tag, " rst_no (R3/R4/R7)"}, DW'(rst_n_o), DW'(er));
    check({tag, " upd_o (R5)"}, DW'(upd), DW'(eu));
    check({tag, " rdata (R6)"}, rdata, model_read(int'(addr)));
  endtask

  // one clock: inputs already set; update model at edge, compare after
  task automatic cycle(string tag);
    bit lk [NUM_CH];
    @(posedge clk);
    for (int i = 0; i < NUM_CH; i++) lk[i] = lock_m[i];
    for (int i = 0; i < NUM_CH; i++) begin
      upd_m[i] = 0;
      if (we && int'(addr) == i && !wdata[0]) lock_m[i] = 0;
      if (we && int'(addr) == NUM_CH + i && lk[i]) begin
        ctrl_m[i] = wdata[0];
        upd_m[i]  = 1;
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr(int a, logic [DW-1:0] d, string tag);
    we = 1; addr = AW'(a); wdata = d;
    cycle(tag);
    we = 0;
  endtask

  task automatic idle(int a, string tag);
    we = 0; addr = AW'(a);
    cycle(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; we = 0;
    model_reset();
    #1;
    // R1 during reset
    for (int a = 0; a < 2*NUM_CH; a++) begin
      addr = AW'(a); #1;
      compare("R1 in reset");
    end
    @(negedge clk);
    rst_ni = 1;
    idle(0, "R1 after reset");
  endtask

  initial begin
    model_reset();
    do_reset();
    // R3 drive channel 0 into reset and back
    wr(NUM_CH + 0, 32'h0, "R3 ctrl0=0");
    idle(NUM_CH + 0, "R3 hold");
    // R8 upper data bits ignored
    wr(NUM_CH + 0, 32'hFFFF_FFFE, "R8 upper bits");
    wr(NUM_CH + 0, 32'h1, "R3 ctrl0=1");
    // R5 same-value write still strobes
    wr(NUM_CH + 0, 32'h1, "R5 same value");
    // R7 channel 1 write leaves channel 0 alone
    wr(NUM_CH + 1, 32'h0, "R7 ctrl1=0");
    // R8 unmapped writes
    wr(2*NUM_CH, 32'h0, "R8 unmapped");
    wr(15, 32'h0, "R8 unmapped top");
    idle(15, "R6 unmapped read");
    // R2 writing 1 to lock is no-op, writing 0 clears
    wr(0, 32'h1, "R2 lock write 1");
    wr(0, 32'hFFFF_FFFE, "R2 lock clear");
    // R10 control write right after lock clear is refused
    wr(NUM_CH + 0, 32'h0, "R10 post-lock write");
    // R4 further writes ignored, no strobe
    wr(NUM_CH + 0, 32'h0, "R4 locked write");
    wr(0, 32'h1, "R2 cannot reopen");
    idle(0, "R2 lock reads 0");
    // R7 channel 1 still writable
    wr(NUM_CH + 1, 32'h1, "R7 ctrl1=1");
    // R9 reset reopens lock
    do_reset();
    wr(NUM_CH + 0, 32'h0, "R9 reopened");
    // pseudo-random traffic with periodic resets
    for (int r = 0; r < 4; r++) begin
      for (int n = 0; n < 150; n++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        we    = lfsr[0];
        addr  = AW'(lfsr[3:1]);
        wdata = {lfsr, lfsr} ^ DW'(lfsr[5] | lfsr[9]);
        cycle("rand R2/R3/R4/R5/R6/R7/R8/R10");
      end
      do_reset();
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule